// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block decides, on every system clock, whether a downstream 16-bit timer/counter may advance. It emits a strobe one system clock wide. A 3-bit select field picks the source of that strobe. The choices are: no source, every clock, one of four fixed divisions of the system clock, or edges on a raw external pin. For the pin, the select code also fixes whether falling or rising edges count.

A free-running 10-bit prescaler runs from reset and supplies the divided rates. A rate fires when the low bits of the prescaler are all ones. The external pin passes through a two-flop synchronizer. A small two-state machine then tracks its last synchronized level. Its states are `LVL_LOW` and `LVL_HIGH`. The transition `LVL_LOW -> LVL_HIGH` marks a rising edge and `LVL_HIGH -> LVL_LOW` marks a falling edge. Both transitions happen in every mode, so the level history stays current whatever the select code. The strobe is registered, so a select value is used on the clock edge that samples it.

Top module: `tmr_clk_select`

## Requirements
- R1: With select code 000 the strobe `count_en_o` stays low.
- R2: With select code 001 the strobe is high in every cycle that follows a cycle in which 001 was applied.
- R3: Codes 010, 011, 100 and 101 divide by 8, 64, 256 and 1024. Let p be the number of clocks since reset was released, modulo 1024. The strobe is high in the cycle after a cycle in which the code was applied and the low 3, 6, 8 or 10 bits of p were all ones.
- R4: With code 110, a falling edge of `ext_pin_i` gives one strobe. The strobe appears after the third rising clock edge that follows the pin change.
- R5: With code 111, a rising edge of `ext_pin_i` gives one strobe, with the same three-edge latency.
- R6: Every qualifying pin edge gives exactly one strobe cycle. The strobe is never high for two cycles in a row.
- R7: Synchronous reset drives the strobe low. It clears the prescaler and sets the synchronizer and level history to low. A pin held high through reset release is therefore seen as one rising edge.
- R8: A new select value takes effect on the next clock and does not restart the prescaler. Divided strobes stay aligned to the count of clocks since reset.
- R9: Pin edges that occur while a non-pin code is selected never produce a strobe, even after a later switch to a pin code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_sel_i | input | 3 | Count source select code |
| ext_pin_i | input | 1 | Raw external count pin, asynchronous |
| count_en_o | output | 1 | Count-enable strobe, one clock wide |

## Verification
The assertions assume that `src_sel_i` changes only between clock edges and is free of glitches at the sampling edge. They also assume that the spacing rules hold only while the select code stays constant across two consecutive cycles. Both the bench and the assertions take the external pin as fully asynchronous; no timing is assumed for it. The stimulus drives the select field and the pin only on falling clock edges. Random select changes are held for at least one cycle, and random pin toggles may come at any cycle rate.

// File: rtl/tcs_pkg.sv
`timescale 1ns/1ps
package tcs_pkg;

    typedef enum logic [2:0] {
        SRC_OFF      = 3'b000,
        SRC_DIRECT   = 3'b001,
        SRC_DIV8     = 3'b010,
        SRC_DIV64    = 3'b011,
        SRC_DIV256   = 3'b100,
        SRC_DIV1024  = 3'b101,
        SRC_PIN_FALL = 3'b110,
        SRC_PIN_RISE = 3'b111
    } src_sel_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } pin_lvl_e;

    localparam int NUM_TAPS = 4;

    // Number of low prescaler bits that must be all ones for tap i.
    function automatic int tap_bits(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tcs_prescaler.sv
`timescale 1ns/1ps
module tcs_prescaler #(
    parameter int PRE_W    = 10,
    parameter int NUM_TAPS = tcs_pkg::NUM_TAPS
) (
    input  logic                clk_i,
    input  logic                rst_i,
    output logic [NUM_TAPS-1:0] tap_o
);

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam int BITS = tcs_pkg::tap_bits(i);
        assign tap_o[i] = &cnt_q[BITS-1:0];
    end

endmodule

// File: rtl/tcs_pin_edge.sv
`timescale 1ns/1ps
module tcs_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    import tcs_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    pin_lvl_e               lvl_q, lvl_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
        end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lvl_q <= LVL_LOW;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    // Next state and outputs
    always_comb begin
        lvl_d  = lvl_q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (lvl_q)
            LVL_LOW: begin
                if (pin_s) begin
                    lvl_d  = LVL_HIGH;
                    rise_o = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!pin_s) begin
                    lvl_d  = LVL_LOW;
                    fall_o = 1'b1;
                end
            end
            default: lvl_d = LVL_LOW;
        endcase
    end

endmodule

// File: rtl/tcs_src_mux.sv
`timescale 1ns/1ps
module tcs_src_mux #(
    parameter int NUM_TAPS = tcs_pkg::NUM_TAPS
) (
    input  logic [2:0]          sel_i,
    input  logic [NUM_TAPS-1:0] tap_i,
    input  logic                rise_i,
    input  logic                fall_i,
    output logic                hit_o
);
    import tcs_pkg::*;

    src_sel_e sel;
    assign sel = src_sel_e'(sel_i);

    always_comb begin
        unique case (sel)
            SRC_OFF:      hit_o = 1'b0;
            SRC_DIRECT:   hit_o = 1'b1;
            SRC_DIV8:     hit_o = tap_i[0];
            SRC_DIV64:    hit_o = tap_i[1];
            SRC_DIV256:   hit_o = tap_i[2];
            SRC_DIV1024:  hit_o = tap_i[3];
            SRC_PIN_FALL: hit_o = fall_i;
            SRC_PIN_RISE: hit_o = rise_i;
            default:      hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_clk_select.sv
`timescale 1ns/1ps
module tmr_clk_select #(
    parameter int PRE_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [2:0] src_sel_i,
    input  logic       ext_pin_i,
    output logic       count_en_o
);
    localparam int NUM_TAPS = tcs_pkg::NUM_TAPS;

    logic [NUM_TAPS-1:0] tap;
    logic                rise, fall, hit;

    tcs_prescaler #(.PRE_W(PRE_W), .NUM_TAPS(NUM_TAPS)) i_pre (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tap_o (tap)
    );

    tcs_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pin_i  (ext_pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    tcs_src_mux #(.NUM_TAPS(NUM_TAPS)) i_mux (
        .sel_i  (src_sel_i),
        .tap_i  (tap),
        .rise_i (rise),
        .fall_i (fall),
        .hit_o  (hit)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_en_o <= 1'b0;
        end else begin
            count_en_o <= hit;
        end
    end

endmodule

// File: rtl/tmr_clk_select_chk.sv
`timescale 1ns/1ps
module tmr_clk_select_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic [2:0] src_sel_i,
    input logic       count_en_o
);

    // R1
    a_r1_stop_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (src_sel_i == 3'b000) |=> !count_en_o);

    // R2
    a_r2_direct_every: assert property (@(posedge clk_i) disable iff (rst_i)
        (src_sel_i == 3'b001) |=> count_en_o);

    // R3
    a_r3_div_spaced: assert property (@(posedge clk_i) disable iff (rst_i)
        (count_en_o && src_sel_i >= 3'b010 && src_sel_i <= 3'b101
         && $past(src_sel_i) == src_sel_i) |=> !count_en_o);

    // R6
    a_r6_pin_one_wide: assert property (@(posedge clk_i) disable iff (rst_i)
        (count_en_o && src_sel_i[2:1] == 2'b11
         && $past(src_sel_i) == src_sel_i) |=> !count_en_o);

endmodule

bind tmr_clk_select tmr_clk_select_chk i_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .src_sel_i  (src_sel_i),
    .count_en_o (count_en_o)
);

// File: tb/test_tmr_clk_select.sv
`timescale 1ns/1ps
module test_tmr_clk_select;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = 3'b000;
    logic       pin = 1'b0;
    logic       count_en;

    int n_run  = 0;
    int n_fail = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tmr_clk_select i_tmr_clk_select (
        .clk_i      (clk),
        .rst_i      (rst),
        .src_sel_i  (sel),
        .ext_pin_i  (pin),
        .count_en_o (count_en)
    );

    // Reference model built from the requirements
    logic [9:0] m_p;
    logic       m_s1, m_s2, m_h, m_en;
    logic [2:0] m_sel1, m_sel2;

    function automatic logic exp_hit(input logic [2:0] s, input logic [9:0] p,
                                     input logic s2, input logic h);
        case (s)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd2: return &p[2:0];
            3'd3: return &p[5:0];
            3'd4: return &p[7:0];
            3'd5: return &p[9:0];
            3'd6: return h & ~s2;
            default: return ~h & s2;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] s, input logic [2:0] sprev);
        if (s != sprev) return "R8";
        case (s)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd6: return "R4";
            3'd7: return "R5";
            default: return "R3";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_p <= '0; m_s1 <= 1'b0; m_s2 <= 1'b0; m_h <= 1'b0; m_en <= 1'b0;
            m_sel1 <= sel; m_sel2 <= sel;
        end else begin
            m_en   <= exp_hit(sel, m_p, m_s2, m_h);
            m_p    <= m_p + 1'b1;
            m_s1   <= pin;
            m_s2   <= m_s1;
            m_h    <= m_s2;
            m_sel1 <= sel;
            m_sel2 <= m_sel1;
        end
    end

    task automatic check(input string req, input logic act, input logic expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !rst) check(tag_of(m_sel1, m_sel2), count_en, m_en);
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R7", count_en, 1'b0);
        rst = 1'b0;
    endtask

    task automatic count_pulses(input int cycles, output int pulses);
        pulses = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (count_en) pulses++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int pulses;
        void'($urandom(32'h5eed_1234));
        do_reset();
        chk_on = 1'b1;

        // Directed: each code held while the pin toggles at random
        for (int c = 0; c < 8; c++) begin
            @(negedge clk); sel = 3'(c);
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if ($urandom_range(0, 5) == 0) pin = ~pin;
            end
        end

        // R3: rate of the slowest division over two full periods
        @(negedge clk); sel = 3'b101;
        count_pulses(1024, pulses);
        count_pulses(2048, pulses);
        check_int("R3", pulses, 2);

        // R6: slow rising edges, one strobe each
        pin = 1'b0; sel = 3'b111;
        repeat (6) @(negedge clk);
        pulses = 0;
        for (int k = 0; k < 4; k++) begin
            int p1;
            pin = 1'b1; count_pulses(6, p1); pulses += p1;
            pin = 1'b0; count_pulses(6, p1); pulses += p1;
        end
        check_int("R6", pulses, 4);

        // R9: edge during a divided code is not counted after the switch
        sel = 3'b010; pin = 1'b0;
        repeat (6) @(negedge clk);
        pin = 1'b1;
        repeat (6) @(negedge clk);
        sel = 3'b111;
        count_pulses(10, pulses);
        check_int("R9", pulses, 0);

        // R7: pin high through reset release counts one rising edge
        chk_on = 1'b0;
        @(negedge clk); rst = 1'b1; sel = 3'b111; pin = 1'b1;
        repeat (2) @(negedge clk);
        check("R7", count_en, 1'b0);
        rst = 1'b0;
        chk_on = 1'b1;
        count_pulses(8, pulses);
        check_int("R7", pulses, 1);

        // Random mix of select changes and pin activity
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) pin = ~pin;
        end

        // Mid-run reset
        chk_on = 1'b0;
        do_reset();
        chk_on = 1'b1;
        sel = 3'b010;
        repeat (40) @(negedge clk);

        @(negedge clk);
        finish_run();
    end

endmodule